// File: doc/BRIEF.md
# Lockable Configuration Word Store

This block keeps the configuration pattern of a small programmable logic device together with a separate user signature area and a one-time security bit. A programming controller sends commands over a command/address/data interface with a valid/ready handshake. The supported commands are configuration write, verify read, register preload, signature write and read, lock, and full erase. Every accepted command gets a single-cycle response one clock later, and a denied command is flagged in that response.

Setting the security bit changes behaviour from the very next command. After that, verify reads return zeros with the denied flag, preloads produce no pulse, and configuration writes are refused. The 64-bit signature, organised as eight bytes, stays readable and writable throughout. The security bit is meant to be the final step of programming. Only a full erase clears it. The erase also sweeps the configuration words to zero, one word per cycle, and holds off new commands while it runs.

Top module: `cfg_lock_store`

## Requirements
- R1: After reset `secured` is 0, `cmd_ready` is 1, `rsp_valid` and `pre_valid` are 0, and every configuration word and signature byte reads back as 0.
- R2: A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both 1. Exactly one cycle later `rsp_valid` is 1 for one cycle. Commands that are not reads respond with `rsp_data` equal to 0.
- R3: Opcode 0 writes `cmd_data` to configuration word `cmd_addr`. Opcode 1 (verify read) returns that word with `rsp_denied` equal to 0 while unlocked.
- R4: Opcode 5 sets `secured`. A verify read accepted on the very next cycle, or at any later point while secured, responds with `rsp_data` equal to 0 and `rsp_denied` equal to 1.
- R5: Opcode 2 (preload) while unlocked pulses `pre_valid` for one cycle, together with the response, carrying `pre_addr` and `pre_data` from the command. While secured it gives no pulse and responds with `rsp_denied` equal to 1.
- R6: A configuration write (opcode 0) while secured responds with `rsp_denied` equal to 1.
- R7: Opcode 3 writes `cmd_data[7:0]` to signature byte `cmd_addr[2:0]`. Opcode 4 reads that byte, zero-extended. Both respond with `rsp_denied` equal to 0 whether or not the block is secured.
- R8: Opcode 6 (erase) clears `secured` on the cycle after acceptance. It holds `cmd_ready` at 0 for exactly DEPTH cycles, after which all configuration words read 0. Signature bytes are kept.
- R9: Opcode 7 is reserved. It responds with `rsp_denied` equal to 1 and changes no state.
- R10: While `cmd_ready` is 0, `cmd_valid` has no effect: no response appears and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Opcode (see R3 to R9) |
| cmd_addr | input | AW (5) | Word address; the low 3 bits select a signature byte |
| cmd_data | input | DW (8) | Write or preload data |
| rsp_valid | output | 1 | Response strobe |
| rsp_denied | output | 1 | Command was refused |
| rsp_data | output | DW (8) | Read data, 0 when refused |
| pre_valid | output | 1 | Preload strobe toward the logic registers |
| pre_addr | output | AW (5) | Preload target register |
| pre_data | output | DW (8) | Preload value |
| secured | output | 1 | Security bit state |

## Verification
Two effects can meet across adjacent cycles. The lock command updates the gate on the same edge that accepts it, so the verify read or preload that follows it directly is the first command judged under the new state. The bench issues lock then read back to back, with no idle cycle between them, and expects the read to be denied with zero data. The second meeting point is an erase overlapping a pending command. A write is presented during the erase sweep, and the bench expects no response and expects that word to read zero once `cmd_ready` returns.

// File: rtl/cls_pkg.sv
package cls_pkg;
   typedef enum logic [2:0] {
      OP_CFG_WR  = 3'd0,
      OP_CFG_RD  = 3'd1,
      OP_PRELOAD = 3'd2,
      OP_SIG_WR  = 3'd3,
      OP_SIG_RD  = 3'd4,
      OP_LOCK    = 3'd5,
      OP_ERASE   = 3'd6,
      OP_RSVD    = 3'd7
   } cls_op_e;

   typedef struct packed {
      logic cfg_wr;
      logic cfg_rd;
      logic pre;
      logic sig_wr;
      logic sig_rd;
      logic lock;
      logic erase;
      logic deny;
   } cls_act_t;
endpackage

// File: rtl/cls_gate.sv
module cls_gate
   import cls_pkg::*;
(
   input  logic     fire,
   input  cls_op_e  op,
   input  logic     secured,
   output cls_act_t act
);
   logic guarded;

   always_comb begin
      guarded = (op == OP_CFG_WR) || (op == OP_CFG_RD) || (op == OP_PRELOAD);
      act = '0;
      if (fire) begin
         act.deny   = (guarded && secured) || (op == OP_RSVD);
         act.cfg_wr = (op == OP_CFG_WR)  && !secured;
         act.cfg_rd = (op == OP_CFG_RD)  && !secured;
         act.pre    = (op == OP_PRELOAD) && !secured;
         act.sig_wr = (op == OP_SIG_WR);
         act.sig_rd = (op == OP_SIG_RD);
         act.lock   = (op == OP_LOCK);
         act.erase  = (op == OP_ERASE);
      end
   end
endmodule

// File: rtl/cls_cfg_array.sv
module cls_cfg_array #(
   parameter  int DEPTH = 32,
   parameter  int DW    = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   input  logic          erase_start,
   output logic [DW-1:0] rd_data,
   output logic          busy
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         ptr     <= '0;
         busy    <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_data <= mem[addr];
         if (erase_start) begin
            busy <= 1'b1;
            ptr  <= '0;
         end else if (busy) begin
            mem[ptr] <= '0;
            ptr      <= ptr + 1'b1;
            if (ptr == LAST) busy <= 1'b0;
         end else if (wr_en) begin
            mem[addr] <= wr_data;
         end
      end
   end

   // R8
   sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |=> busy);
endmodule

// File: rtl/cls_sig_store.sv
module cls_sig_store #(
   parameter  int BYTES = 8,
   localparam int SAW   = $clog2(BYTES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [SAW-1:0] addr,
   input  logic [7:0]     wr_data,
   output logic [7:0]     rd_data
);
   logic [7:0] sig_b [BYTES];

   for (genvar g = 0; g < BYTES; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              sig_b[g] <= '0;
         else if (wr_en && addr == SAW'(g))       sig_b[g] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= sig_b[addr];
   end
endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store
   import cls_pkg::*;
#(
   parameter  int DEPTH     = 32,
   parameter  int DW        = 8,
   parameter  int SIG_BYTES = 8,
   localparam int AW        = $clog2(DEPTH),
   localparam int SAW       = $clog2(SIG_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic [2:0]    cmd_op,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_data,
   output logic          rsp_valid,
   output logic          rsp_denied,
   output logic [DW-1:0] rsp_data,
   output logic          pre_valid,
   output logic [AW-1:0] pre_addr,
   output logic [DW-1:0] pre_data,
   output logic          secured
);
   if (DW < 8)                 begin : g_bad_dw    $error("DW must be at least 8"); end
   if (DEPTH < 2 || (1 << AW) != DEPTH)
                               begin : g_bad_depth $error("DEPTH must be a power of two, at least 2"); end
   if (AW < SAW || SIG_BYTES < 2)
                               begin : g_bad_sig   $error("signature must fit the address"); end

   cls_op_e  op;
   cls_act_t act;
   logic     fire, busy;
   logic     sel_cfg, sel_sig;
   logic [DW-1:0] cfg_q;
   logic [7:0]    sig_q;

   assign op        = cls_op_e'(cmd_op);
   assign cmd_ready = !busy;
   assign fire      = cmd_valid && cmd_ready;

   cls_gate u_gate (.fire(fire), .op(op), .secured(secured), .act(act));

   cls_cfg_array #(.DEPTH(DEPTH), .DW(DW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(act.cfg_wr), .addr(cmd_addr),
      .wr_data(cmd_data), .erase_start(act.erase), .rd_data(cfg_q), .busy(busy));

   cls_sig_store #(.BYTES(SIG_BYTES)) u_sig (
      .clk(clk), .rst_n(rst_n), .wr_en(act.sig_wr), .addr(cmd_addr[SAW-1:0]),
      .wr_data(cmd_data[7:0]), .rd_data(sig_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secured    <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_denied <= 1'b0;
         sel_cfg    <= 1'b0;
         sel_sig    <= 1'b0;
         pre_valid  <= 1'b0;
         pre_addr   <= '0;
         pre_data   <= '0;
      end else begin
         if (act.erase)     secured <= 1'b0;
         else if (act.lock) secured <= 1'b1;
         rsp_valid  <= fire;
         rsp_denied <= act.deny;
         sel_cfg    <= act.cfg_rd;
         sel_sig    <= act.sig_rd;
         pre_valid  <= act.pre;
         if (act.pre) begin
            pre_addr <= cmd_addr;
            pre_data <= cmd_data;
         end
      end
   end

   always_comb begin
      rsp_data = '0;
      if (sel_cfg)      rsp_data = cfg_q;
      else if (sel_sig) rsp_data = DW'(sig_q);
   end

   // R2
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_valid);
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !rsp_valid);
   // R4
   locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op == OP_CFG_RD && secured) |=> (rsp_denied && rsp_data == '0));
   // R5
   locked_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op == OP_PRELOAD && secured) |=> !pre_valid);
   // R7
   sig_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (op == OP_SIG_RD || op == OP_SIG_WR)) |=> !rsp_denied);
   // R8
   erase_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op == OP_ERASE) |=> (!secured && !cmd_ready));
endmodule

// File: tb/sim_cfg_lock_store.sv
module sim_cfg_lock_store;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 32;
   localparam int DW    = 8;
   localparam int AW    = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic cmd_ready, rsp_valid, rsp_denied, pre_valid, secured;
   logic [DW-1:0] rsp_data, pre_data;
   logic [AW-1:0] pre_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] mem_m [DEPTH];
   logic [7:0]    sig_m [8];
   bit            lock_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_lock_store #(.DEPTH(DEPTH), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .rsp_valid(rsp_valid), .rsp_denied(rsp_denied), .rsp_data(rsp_data),
      .pre_valid(pre_valid), .pre_addr(pre_addr), .pre_data(pre_data),
      .secured(secured));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_denied(input int op, input bit lk);
      return (op == 7) || (lk && (op <= 2));
   endfunction

   function automatic int exp_data(input int op, input int a, input bit lk);
      if (op == 1 && !lk) return int'(mem_m[a]);
      if (op == 4)        return int'(sig_m[a % 8]);
      return 0;
   endfunction

   task automatic issue(input int op, input int a, input int d, input string tag);
      bit lk;
      int ed;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = AW'(a); cmd_data = DW'(d);
      @(negedge clk);
      cmd_valid = 1'b0;
      lk = lock_m;
      ed = exp_data(op, a, lk);
      chk(rsp_valid == 1'b1, {tag, " R2 rsp_valid"}, int'(rsp_valid), 1);
      chk(rsp_denied == exp_denied(op, lk), {tag, " denied"}, int'(rsp_denied), int'(exp_denied(op, lk)));
      chk(int'(rsp_data) == ed, {tag, " data"}, int'(rsp_data), ed);
      chk(pre_valid == (op == 2 && !lk), {tag, " R5 pre_valid"}, int'(pre_valid), int'(op == 2 && !lk));
      if (op == 2 && !lk)
         chk(int'(pre_addr) == a && int'(pre_data) == d, {tag, " R5 pre fields"},
             int'({pre_addr, pre_data}), (a << DW) | d);
      case (op)
         0: if (!lk) mem_m[a] = DW'(d);
         3: sig_m[a % 8] = 8'(d);
         5: lock_m = 1'b1;
         6: begin
            lock_m = 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
         end
         default: ;
      endcase
      chk(secured == lock_m, {tag, " secured"}, int'(secured), int'(lock_m));
   endtask

   task automatic erase_seq(input string tag);
      int n;
      issue(6, 0, 0, {tag, " R8 erase"});
      chk(cmd_ready == 1'b0, {tag, " R8 busy"}, int'(cmd_ready), 0);
      // R10: command presented during the sweep must be ignored
      cmd_valid = 1'b1; cmd_op = 3'd0; cmd_addr = '0; cmd_data = 8'hFF;
      @(negedge clk);
      cmd_valid = 1'b0;
      n = 1;
      chk(rsp_valid == 1'b0, {tag, " R10 no rsp when busy"}, int'(rsp_valid), 0);
      while (!cmd_ready) begin @(negedge clk); n++; end
      chk(n == DEPTH, {tag, " R8 busy length"}, n, DEPTH);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int r, op;
      void'($urandom(32'd4242));
      for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
      for (int i = 0; i < 8; i++) sig_m[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(secured == 0 && cmd_ready == 1 && rsp_valid == 0 && pre_valid == 0,
          "R1 reset outputs", int'({secured, cmd_ready, rsp_valid, pre_valid}), 4'b0100);
      rst_n = 1'b1;
      issue(1, 7, 0, "R1 cfg zero");
      issue(4, 3, 0, "R1 sig zero");
      // R3
      issue(0, 7, 8'hA5, "R3 write");
      issue(1, 7, 0, "R3 read");
      issue(0, 31, 8'h3C, "R3 write top");
      issue(1, 31, 0, "R3 read top");
      // R5 unlocked preload
      issue(2, 9, 8'h5A, "R5 preload open");
      // R7 signature
      issue(3, 5, 8'hC3, "R7 sig write");
      issue(4, 13, 0, "R7 sig read via low bits");
      // R9 reserved
      issue(7, 7, 8'h11, "R9 reserved");
      issue(1, 7, 0, "R9 no change");
      // R4 lock then immediate read, back to back
      issue(5, 0, 0, "R4 lock");
      issue(1, 7, 0, "R4 read right after lock");
      issue(2, 9, 8'h77, "R5 preload locked");
      issue(0, 7, 8'h99, "R6 write locked");
      issue(3, 6, 8'h81, "R7 sig write locked");
      issue(4, 6, 0, "R7 sig read locked");
      // R8 erase with overlapping command
      erase_seq("R8 directed");
      issue(1, 0, 0, "R10 ignored write not stored");
      issue(1, 7, 0, "R8 cleared");
      issue(4, 5, 0, "R8 sig kept");
      // random phase
      for (int k = 0; k < 400; k++) begin
         r = int'($urandom % 40);
         if (r == 0)       op = 6;
         else if (r < 3)   op = 5;
         else if (r < 4)   op = 7;
         else              op = int'($urandom % 5);
         if (op == 6) erase_seq("R8 random");
         else issue(op, int'($urandom % DEPTH), int'($urandom % 256), "R3 R4 R7 random");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule